// File: doc/BRIEF.md
# Station-Address PROM Read Responder

This block answers host I/O reads aimed at a 16-byte, byte-wide station-address PROM that hangs off a private data bus shared with other agents. When the host issues a read strobe with the address-enable line low and an address inside the PROM's 16-byte window, the block holds the host in wait by pulling its ready line low. It then requests the private bus from an external arbiter. If the grant is already parked on it, no request delay is needed.

Once the grant is seen, the block selects the PROM, presents the addressed byte on the low eight bits of the system data bus and releases the wait. The chip select, the request and the low-byte drive stay up until the read strobe falls. They all drop on the following clock. The block only ever answers as an 8-bit device. A 16-bit software access arrives as two byte reads, and each is served on its own.

All host inputs are taken as already synchronous to `clk`. Reset is synchronous and active high.

Top module: `prom_io_responder`

## Requirements
- R1: While reset is held and on the first clock after it, host ready is high and bus request, PROM select and low-byte output enable are all low.
- R2: A cycle starts only when address enable is low, the read strobe is high and the address bits above bit 3 equal those of the window base (default 0x300). Any other combination leaves ready high and request and select low.
- R3: In the clock a cycle is detected, ready goes low combinationally. It stays low on every clock until the PROM select is asserted.
- R4: When the grant is not present at detection, the bus request rises on the next clock. It stays high through the whole wait and data phases.
- R5: The clock after the grant is sampled, PROM select and low-byte output enable are high and ready is high. The PROM address equals address bits 3:0 latched at detection, and the low data byte equals the PROM byte at that address. With an arbiter that grants D clocks after it first sees the request, select appears 3+D clocks after detection.
- R6: The 16-bit-cycle indicator (active low) stays high and the high-byte output enable stays low at all times.
- R7: Once the read strobe falls during the data phase, select, low-byte output enable and bus request are all low on the next clock. Ready stays high.
- R8: If the grant is already high when the cycle is detected, select is asserted on the very next clock. Ready is low only in the detection clock.
- R9: Back-to-back byte reads at adjacent addresses (even then odd) are served independently, each returning its own byte.
- R10: If the read strobe falls before select is asserted, the request drops on the next clock and select is never asserted. This also holds when the grant arrives on the same clock that the strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_aen | input | 1 | Address enable from host bus; cycles only decoded when low |
| host_addr | input | ADDR_W | Host I/O address |
| host_rd | input | 1 | Host I/O read strobe, active high |
| host_rdy | output | 1 | Host ready; low inserts wait states |
| host_io16_n | output | 1 | 16-bit I/O cycle indicator, active low, never asserted |
| bus_req | output | 1 | Private data bus request to arbiter |
| bus_gnt | input | 1 | Private data bus grant from arbiter |
| prom_cs | output | 1 | PROM chip select |
| prom_addr | output | 4 | PROM byte address |
| prom_data | input | 8 | PROM data byte |
| sd_lo_out | output | 8 | Low system data byte |
| sd_lo_oe | output | 1 | Output enable for the low system data byte |
| sd_hi_oe | output | 1 | Output enable for the high system data byte, held low |

## Verification
The grant can arrive on the same clock that the host withdraws its read strobe, so the state machine sees both a reason to drive and a reason to stop. The bench uses an arbiter model with a programmable delay to provoke this. It drops the strobe on the half-cycle after the grant rises, so both reach the sequencer at one edge. The abort must win: select and output enable stay low and the request falls on the next clock. Ordinary grant delays of zero to several clocks are also timed against the expected select clock.

// File: rtl/prom_rsp_pkg.sv
package prom_rsp_pkg;

    // byte-wide PROM of 16 entries
    localparam int PROM_BYTES = 16;
    localparam int PROM_IDX_W = $clog2(PROM_BYTES);
    localparam int PROM_DW    = 8;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_WAIT  = 2'd1,
        PS_DRIVE = 2'd2
    } prom_state_e;

    // decoded host access
    typedef struct packed {
        logic                  hit;
        logic [PROM_IDX_W-1:0] idx;
    } prom_sel_t;

    // per-state control bundle
    typedef struct packed {
        logic req;
        logic cs;
        logic oe;
        logic hold;
    } prom_ctl_t;

    function automatic prom_ctl_t ctl_of(prom_state_e st);
        prom_ctl_t c;
        c = '0;
        case (st)
            PS_WAIT: begin
                c.req  = 1'b1;
                c.hold = 1'b1;
            end
            PS_DRIVE: begin
                c.req = 1'b1;
                c.cs  = 1'b1;
                c.oe  = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/prom_win_dec.sv
module prom_win_dec
    import prom_rsp_pkg::*;
#(
    parameter int          ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] WIN_BASE = 10'h300
) (
    input  logic              aen,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    output prom_sel_t         sel
);
    localparam int TAG_W = ADDR_W - PROM_IDX_W;

    logic [TAG_W-1:0] tag_in;
    logic [TAG_W-1:0] tag_base;
    logic             in_window;

    assign tag_in    = addr[ADDR_W-1:PROM_IDX_W];
    assign tag_base  = WIN_BASE[ADDR_W-1:PROM_IDX_W];
    assign in_window = (tag_in == tag_base);

    always_comb begin
        sel.hit = in_window && !aen && rd;
        sel.idx = addr[PROM_IDX_W-1:0];
    end
endmodule

// File: rtl/prom_seq_fsm.sv
module prom_seq_fsm
    import prom_rsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  prom_sel_t sel,
    input  logic      rd,
    input  logic      gnt,
    output prom_ctl_t ctl,
    output logic      start,
    output logic      stall
);
    prom_state_e state_q;
    prom_state_e state_d;

    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        case (state_q)
            PS_IDLE: begin
                if (sel.hit) begin
                    start   = 1'b1;
                    state_d = gnt ? PS_DRIVE : PS_WAIT;
                end
            end
            PS_WAIT: begin
                // abort takes priority over a grant seen on the same edge
                if (!rd)
                    state_d = PS_IDLE;
                else if (gnt)
                    state_d = PS_DRIVE;
            end
            PS_DRIVE: begin
                if (!rd)
                    state_d = PS_IDLE;
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PS_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        ctl   = ctl_of(state_q);
        stall = ctl.hold || ((state_q == PS_IDLE) && sel.hit);
    end
endmodule

// File: rtl/prom_byte_path.sv
module prom_byte_path
    import prom_rsp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [PROM_IDX_W-1:0] idx_in,
    input  logic                  oe,
    input  logic [PROM_DW-1:0]    rom_byte,
    output logic [PROM_IDX_W-1:0] rom_idx,
    output logic [PROM_DW-1:0]    sys_byte
);
    logic [PROM_IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (load)
            idx_q <= idx_in;
    end

    assign rom_idx  = idx_q;
    assign sys_byte = oe ? rom_byte : '0;
endmodule

// File: rtl/prom_io_responder.sv
module prom_io_responder
    import prom_rsp_pkg::*;
#(
    parameter int                ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] WIN_BASE = 10'h300
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_aen,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic                  host_rd,
    output logic                  host_rdy,
    output logic                  host_io16_n,
    output logic                  bus_req,
    input  logic                  bus_gnt,
    output logic                  prom_cs,
    output logic [PROM_IDX_W-1:0] prom_addr,
    input  logic [PROM_DW-1:0]    prom_data,
    output logic [PROM_DW-1:0]    sd_lo_out,
    output logic                  sd_lo_oe,
    output logic                  sd_hi_oe
);
    prom_sel_t sel;
    prom_ctl_t ctl;
    logic      start;
    logic      stall;

    prom_win_dec #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE)
    ) u_dec (
        .aen  (host_aen),
        .addr (host_addr),
        .rd   (host_rd),
        .sel  (sel)
    );

    prom_seq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .rd    (host_rd),
        .gnt   (bus_gnt),
        .ctl   (ctl),
        .start (start),
        .stall (stall)
    );

    prom_byte_path u_path (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .idx_in   (sel.idx),
        .oe       (ctl.oe),
        .rom_byte (prom_data),
        .rom_idx  (prom_addr),
        .sys_byte (sd_lo_out)
    );

    assign host_rdy    = !stall;
    assign bus_req     = ctl.req;
    assign prom_cs     = ctl.cs;
    assign sd_lo_oe    = ctl.oe;
    assign sd_hi_oe    = 1'b0;  // byte-only device
    assign host_io16_n = 1'b1;
endmodule

// File: rtl/prom_io_responder_chk.sv
module prom_io_responder_chk
    import prom_rsp_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  host_rd,
    input logic                  host_rdy,
    input logic                  bus_req,
    input logic                  bus_gnt,
    input logic                  prom_cs,
    input logic                  sd_lo_oe,
    input logic [PROM_IDX_W-1:0] prom_addr
);
    AST_WAIT_HOLDS_HOST: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !prom_cs && host_rd) |-> !host_rdy); // R3

    AST_OE_UNDER_REQ: assert property (@(posedge clk) disable iff (rst)
        sd_lo_oe |-> bus_req); // R4

    AST_CS_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(prom_cs) |-> ($past(bus_gnt) && $past(host_rd))); // R5

    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
        (prom_cs && $past(prom_cs)) |-> $stable(prom_addr)); // R5

    AST_RELEASE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (prom_cs && !host_rd) |=> (!prom_cs && !sd_lo_oe && !bus_req)); // R7

    AST_ABORT_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !prom_cs && !host_rd) |=> (!prom_cs && !bus_req)); // R10
endmodule

bind prom_io_responder prom_io_responder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_rd   (host_rd),
    .host_rdy  (host_rdy),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .prom_cs   (prom_cs),
    .sd_lo_oe  (sd_lo_oe),
    .prom_addr (prom_addr)
);

// File: tb/prom_io_responder_test.sv
module prom_io_responder_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       host_aen;
    logic [9:0] host_addr;
    logic       host_rd;
    logic       host_rdy;
    logic       host_io16_n;
    logic       bus_req;
    logic       bus_gnt;
    logic       prom_cs;
    logic [3:0] prom_addr;
    logic [7:0] prom_data;
    logic [7:0] sd_lo_out;
    logic       sd_lo_oe;
    logic       sd_hi_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // arbiter model
    int   arb_dly  = 0;
    int   arb_cnt  = 0;
    bit   arb_park = 0;

    always #4 clk = ~clk;

    prom_io_responder uut (
        .clk(clk), .rst(rst), .host_aen(host_aen), .host_addr(host_addr),
        .host_rd(host_rd), .host_rdy(host_rdy), .host_io16_n(host_io16_n),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .prom_cs(prom_cs),
        .prom_addr(prom_addr), .prom_data(prom_data), .sd_lo_out(sd_lo_out),
        .sd_lo_oe(sd_lo_oe), .sd_hi_oe(sd_hi_oe)
    );

    function automatic logic [7:0] rom_val(logic [3:0] a);
        return 8'hA5 ^ (8'(a) * 8'h1B);
    endfunction

    assign prom_data = rom_val(prom_addr);

    always @(posedge clk) begin
        if (rst) begin
            bus_gnt <= 1'b0;
            arb_cnt <= 0;
        end else if (arb_park) begin
            bus_gnt <= 1'b1;
        end else if (!bus_req) begin
            bus_gnt <= 1'b0;
            arb_cnt <= 0;
        end else if (arb_cnt >= arb_dly) begin
            bus_gnt <= 1'b1;
        end else begin
            arb_cnt <= arb_cnt + 1;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // full read with grant delay dly; expects service when hit
    task automatic do_read(logic [9:0] a, logic aen, int dly, logic hit, string tag);
        int waited;
        arb_dly = dly;
        @(negedge clk);
        host_addr = a; host_aen = aen; host_rd = 1'b1;
        #1;
        check({tag, " R2/R3 ready at detect"}, host_rdy, !hit);
        if (!hit) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                check({tag, " R2 no req"}, bus_req, 0);
                check({tag, " R2 no cs"}, prom_cs, 0);
                check({tag, " R2 ready"}, host_rdy, 1);
            end
            host_rd = 1'b0;
            return;
        end
        waited = 0;
        while (!prom_cs && waited < 40) begin
            @(negedge clk);
            waited++;
            if (!prom_cs) begin
                check({tag, " R3 ready low in wait"}, host_rdy, 0);
                check({tag, " R4 req in wait"}, bus_req, 1);
            end
        end
        check({tag, " R5 select clock"}, waited, 3 + dly);
        check({tag, " R5 oe"}, sd_lo_oe, 1);
        check({tag, " R5 ready released"}, host_rdy, 1);
        check({tag, " R5 prom addr"}, prom_addr, a[3:0]);
        check({tag, " R5 data"}, sd_lo_out, rom_val(a[3:0]));
        check({tag, " R6 io16"}, host_io16_n, 1);
        check({tag, " R6 hi oe"}, sd_hi_oe, 0);
        @(negedge clk);
        check({tag, " R5 data held"}, sd_lo_out, rom_val(a[3:0]));
        host_rd = 1'b0;
        #1;
        check({tag, " R7 cs until edge"}, prom_cs, 1);
        @(negedge clk);
        check({tag, " R7 cs drop"}, prom_cs, 0);
        check({tag, " R7 oe drop"}, sd_lo_oe, 0);
        check({tag, " R7 req drop"}, bus_req, 0);
        check({tag, " R7 ready"}, host_rdy, 1);
    endtask

    // addr(10) aen(1) dly(4) hit(1)
    localparam logic [15:0] VECS [0:7] = '{
        {10'h300, 1'b0, 4'd0, 1'b1},
        {10'h301, 1'b0, 4'd2, 1'b1},
        {10'h30F, 1'b0, 4'd5, 1'b1},
        {10'h310, 1'b0, 4'd1, 1'b0},
        {10'h2FF, 1'b0, 4'd1, 1'b0},
        {10'h305, 1'b1, 4'd1, 1'b0},
        {10'h304, 1'b0, 4'd3, 1'b1},   // R9 even byte
        {10'h305, 1'b0, 4'd0, 1'b1}    // R9 odd byte
    };

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; host_aen = 1'b1; host_addr = '0; host_rd = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset ready", host_rdy, 1);
        check("R1 reset req", bus_req, 0);
        check("R1 reset cs", prom_cs, 0);
        check("R1 reset oe", sd_lo_oe, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset req", bus_req, 0);
        check("R1 post-reset cs", prom_cs, 0);

        for (int v = 0; v < 8; v++)
            do_read(VECS[v][15:6], VECS[v][5], int'(VECS[v][4:1]), VECS[v][0], "vec");

        // R8: parked grant
        arb_park = 1;
        @(negedge clk);
        @(negedge clk);
        host_addr = 10'h30A; host_aen = 1'b0; host_rd = 1'b1;
        #1;
        check("R8 ready low at detect", host_rdy, 0);
        @(negedge clk);
        check("R8 cs next clock", prom_cs, 1);
        check("R8 ready high", host_rdy, 1);
        check("R8 data", sd_lo_out, rom_val(4'hA));
        host_rd = 1'b0;
        @(negedge clk);
        check("R8 cs drop", prom_cs, 0);
        arb_park = 0;
        repeat (2) @(negedge clk);

        // R10: abort well before grant
        arb_dly = 10;
        host_addr = 10'h303; host_rd = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 req during wait", bus_req, 1);
        host_rd = 1'b0;
        @(negedge clk);
        check("R10 req dropped", bus_req, 0);
        check("R10 no cs", prom_cs, 0);
        check("R10 ready", host_rdy, 1);
        repeat (2) @(negedge clk);

        // R10: grant and strobe drop meet at one edge
        arb_dly = 2;
        host_addr = 10'h306; host_rd = 1'b1;     // detect at negedge 0
        repeat (4) @(negedge clk);                // negedge 2+dly: gnt just rose
        check("R10 grant present", bus_gnt, 1);
        check("R10 cs not yet", prom_cs, 0);
        host_rd = 1'b0;
        @(negedge clk);
        check("R10 collide no cs", prom_cs, 0);
        check("R10 collide no oe", sd_lo_oe, 0);
        check("R10 collide req low", bus_req, 0);
        @(negedge clk);
        check("R6 io16 idle", host_io16_n, 1);

        finish_run();
    end
endmodule